// File: doc/BRIEF.md
# Cartridge Bus Address Decoder

This block sits between a 24-bit console address bus and the memories a game cartridge system holds. Each cycle it takes the bank byte and 16-bit offset of the bus address, together with a static mode input that picks one of two cartridge layouts. The first layout places 32 KB of ROM in the upper half of every bank. The second places 64 KB of ROM in every bank. From these it works out which target responds: cartridge ROM, battery-backed cartridge SRAM, console work RAM (WRAM) or the hardware-register window. It also gives the linear byte offset into that target.

The upper half of the bank space mirrors the lower half. Banks `$7E`/`$7F` always belong to WRAM, so the last two ROM chunks are reached only through banks `$FE`/`$FF`. The bottom 8 KB of every system bank is a shadow of the start of WRAM.

A one-bit memory-speed register is written through the normal bus, with a write strobe at offset `$420D` of any system bank. That bit decides whether accesses to banks `$80`-`$FF` run on the fast cycle. Addresses that hit nothing raise an open-bus flag. All results are registered and appear one clock after the address.

Top module: `cart_map_decoder`

## Requirements
- R1: Exactly one of `sel_rom`, `sel_sram`, `sel_wram`, `sel_io`, `open_bus` is high in every cycle. Each offset output is zero unless its own select is high. Reset gives `open_bus`=1, all other selects 0, all offsets 0 and `fast_cycle`=0.
- R2: Every output reflects the address and mode sampled at the previous rising clock edge.
- R3: With `map_hi`=0, offsets `$8000`-`$FFFF` of any bank other than `$7E`/`$7F` select ROM at `((bank & $7F) << 15) | (offset & $7FFF)`.
- R4: With `map_hi`=1, ROM is selected at `((bank & $3F) << 16) | offset` in two cases: for every offset of banks whose low seven bits lie in `$40`-`$7F` (except `$7E`/`$7F`), and for offsets `$8000`-`$FFFF` of system banks.
- R5: Banks `$7E`/`$7F` select WRAM at `((bank & 1) << 16) | offset` in both modes. Banks `$80`-`$FF` decode like `bank & $7F`, so banks `$FE`/`$FF` reach the top ROM chunks.
- R6: In system banks (low seven bits `$00`-`$3F`), offsets `$0000`-`$1FFF` select WRAM at the same offset.
- R7: In system banks, offsets `$2100`-`$21FF` and `$4200`-`$44FF` select the register window.
- R8: With `map_hi`=0, offsets `$0000`-`$7FFF` of banks `$70`-`$7D`, `$F0`-`$FD` and `$FE`-`$FF` select SRAM. The SRAM offset is `((bank & $F) << 15) | offset` reduced modulo 2^`SRAM_AW`.
- R9: With `map_hi`=1, offsets `$6000`-`$7FFF` of banks whose low seven bits lie in `$20`-`$3F` select SRAM. The SRAM offset is `((bank & $1F) << 13) | (offset & $1FFF)` modulo 2^`SRAM_AW`.
- R10: A bus cycle with `wr_en`=1 at offset `$420D` of a system bank loads `wr_speed_bit` into the speed bit, effective from the next address. Writes to any other address leave the bit unchanged. `fast_cycle` = (bank ≥ `$80`) AND speed bit.
- R11: Any address that no rule above matches raises `open_bus`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 24 | Bank byte [23:16] and offset [15:0] |
| map_hi | input | 1 | 0: 32 KB-per-bank layout, 1: 64 KB-per-bank layout |
| wr_en | input | 1 | Bus write strobe for this cycle |
| wr_speed_bit | input | 1 | Data bit 0 of the bus write |
| sel_rom | output | 1 | Cartridge ROM selected |
| sel_sram | output | 1 | Cartridge SRAM selected |
| sel_wram | output | 1 | Work RAM selected |
| sel_io | output | 1 | Hardware-register window selected |
| open_bus | output | 1 | No target responds |
| rom_off | output | 22 | Linear ROM byte offset |
| sram_off | output | 19 | Linear SRAM byte offset, wrapped to `SRAM_AW` bits |
| wram_off | output | 17 | Linear WRAM byte offset |
| fast_cycle | output | 1 | Fast access cycle for this address |

## Verification
Every select, offset and speed result is due exactly one clock after its address is driven. The bench drives each address on a falling edge and samples the outputs shortly after the following rising edge. It compares them against a behavioural model evaluated on the inputs of the previous cycle.

A speed-register write changes the model's speed bit only after that comparison is made. The written value is therefore first expected on the address that follows the write, which matches the one-cycle delay of the register.

// File: rtl/cmap_pkg.sv
// Shared widths and types for the cartridge address decoder.
package cmap_pkg;
    localparam int BANK_W    = 8;
    localparam int OFFS_W    = 16;
    localparam int ROM_AW    = 22;   // 4 MB of ROM space
    localparam int SRAM_LAW  = 19;   // 512 KB linear SRAM window
    localparam int WRAM_AW   = 17;   // 128 KB of work RAM

    typedef enum logic [2:0] {
        RGN_NONE = 3'd0,
        RGN_ROM  = 3'd1,
        RGN_SRAM = 3'd2,
        RGN_WRAM = 3'd3,
        RGN_IO   = 3'd4
    } region_e;

    typedef struct packed {
        region_e                 region;
        logic [ROM_AW-1:0]       rom;
        logic [SRAM_LAW-1:0]     sram;
        logic [WRAM_AW-1:0]      wram;
    } decode_t;
endpackage

// File: rtl/cmap_sys_dec.sv
// System-area decoder: the WRAM banks, the low-RAM shadow and the register window.
// These rules are the same in both layouts and take priority over them.
// Assumes bank[7] only matters for telling $7E/$7F apart from $FE/$FF.
module cmap_sys_dec
    import cmap_pkg::*;
(
    input  logic [BANK_W-1:0]  bank,
    input  logic [OFFS_W-1:0]  offs,
    output logic               hit,
    output decode_t            dec
);
    // Classify the address against the fixed system regions.
    always_comb begin
        hit = 1'b0;
        dec = '0;
        dec.region = RGN_NONE;
        if (bank[7:1] == 7'h3F) begin
            hit        = 1'b1;
            dec.region = RGN_WRAM;
            dec.wram   = {bank[0], offs};
        end else if (!bank[6]) begin
            if (offs[15:13] == 3'b000) begin
                hit        = 1'b1;
                dec.region = RGN_WRAM;
                dec.wram   = {4'b0000, offs[12:0]};
            end else if (offs[15:8] == 8'h21 ||
                        (offs[15:8] >= 8'h42 && offs[15:8] <= 8'h44)) begin
                hit        = 1'b1;
                dec.region = RGN_IO;
            end
        end
    end
endmodule

// File: rtl/cmap_lo_dec.sv
// Decoder for the 32 KB-per-bank layout: ROM in the upper half of each bank,
// SRAM in the lower half of banks $70-$7D and their mirrors, plus $FE/$FF.
// Assumes the system decoder has already claimed the WRAM banks.
module cmap_lo_dec
    import cmap_pkg::*;
(
    input  logic [BANK_W-1:0]  bank,
    input  logic [OFFS_W-1:0]  offs,
    output decode_t            dec
);
    logic [6:0] low7;
    assign low7 = bank[6:0];

    // Pick ROM or SRAM by offset half and bank range.
    always_comb begin
        dec = '0;
        dec.region = RGN_NONE;
        if (offs[15]) begin
            dec.region = RGN_ROM;
            dec.rom    = {low7, offs[14:0]};
        end else if ((low7 >= 7'h70 && low7 <= 7'h7D) || bank[7:1] == 7'h7F) begin
            dec.region = RGN_SRAM;
            dec.sram   = {bank[3:0], offs[14:0]};
        end
    end
endmodule

// File: rtl/cmap_hi_dec.sv
// Decoder for the 64 KB-per-bank layout: full ROM banks from $40 up, the upper
// half of system banks mirrors the same chunk, SRAM windows in banks $20-$3F.
// Receives only the low seven bank bits, since both halves decode alike.
module cmap_hi_dec
    import cmap_pkg::*;
(
    input  logic [6:0]         bank7,
    input  logic [OFFS_W-1:0]  offs,
    output decode_t            dec
);
    // Pick ROM or SRAM by bank range and offset window.
    always_comb begin
        dec = '0;
        dec.region = RGN_NONE;
        if (bank7[6] || offs[15]) begin
            dec.region = RGN_ROM;
            dec.rom    = {bank7[5:0], offs};
        end else if (bank7[5] && offs[15:13] == 3'b011) begin
            dec.region = RGN_SRAM;
            dec.sram   = {1'b0, bank7[4:0], offs[12:0]};
        end
    end
endmodule

// File: rtl/cmap_speed_reg.sv
// One-bit memory-speed register written by a bus store to SPEED_OFF in any
// system bank. Assumes the write strobe is qualified for one cycle per store.
module cmap_speed_reg
    import cmap_pkg::*;
#(
    parameter logic [OFFS_W-1:0] SPEED_OFF = 16'h420D
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [BANK_W-1:0]  bank,
    input  logic [OFFS_W-1:0]  offs,
    input  logic               wr_en,
    input  logic               wr_bit,
    output logic               speed_q
);
    logic hit;
    assign hit = wr_en && !bank[6] && (offs == SPEED_OFF);

    // Load the speed bit on a matching store; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)   speed_q <= 1'b0;
        else if (hit) speed_q <= wr_bit;
    end

    // R10: a store anywhere else leaves the bit alone.
    assert_speed_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && !bank[6] && offs == SPEED_OFF) |=> $stable(speed_q));
endmodule

// File: rtl/cart_map_decoder.sv
// Cartridge bus address decoder, top level. Combines the system-area decoder
// with the decoder of the selected layout, wraps the SRAM offset to SRAM_AW
// bits and registers all results. Latency is one clock. Assumes map_hi is
// static for a given cartridge.
module cart_map_decoder
    import cmap_pkg::*;
#(
    parameter int SRAM_AW = 13
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [23:0]          bus_addr,
    input  logic                 map_hi,
    input  logic                 wr_en,
    input  logic                 wr_speed_bit,
    output logic                 sel_rom,
    output logic                 sel_sram,
    output logic                 sel_wram,
    output logic                 sel_io,
    output logic                 open_bus,
    output logic [ROM_AW-1:0]    rom_off,
    output logic [SRAM_LAW-1:0]  sram_off,
    output logic [WRAM_AW-1:0]   wram_off,
    output logic                 fast_cycle
);
    localparam logic [SRAM_LAW-1:0] SRAM_MASK = SRAM_LAW'((64'd1 << SRAM_AW) - 64'd1);

    logic [BANK_W-1:0] bank;
    logic [OFFS_W-1:0] offs;
    assign bank = bus_addr[23:16];
    assign offs = bus_addr[15:0];

    logic    sys_hit;
    decode_t sys_dec, lo_dec, hi_dec, pick;
    logic    speed_q;

    cmap_sys_dec u_sys (.bank(bank), .offs(offs), .hit(sys_hit), .dec(sys_dec));
    cmap_lo_dec  u_lo  (.bank(bank), .offs(offs), .dec(lo_dec));
    cmap_hi_dec  u_hi  (.bank7(bank[6:0]), .offs(offs), .dec(hi_dec));

    cmap_speed_reg u_speed (
        .clk(clk), .rst_n(rst_n), .bank(bank), .offs(offs),
        .wr_en(wr_en), .wr_bit(wr_speed_bit), .speed_q(speed_q)
    );

    // Resolve priority: system area first, then the active layout.
    always_comb begin
        if (sys_hit)     pick = sys_dec;
        else if (map_hi) pick = hi_dec;
        else             pick = lo_dec;
    end

    // Register selects, offsets and speed flag; offsets zero when unselected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_rom    <= 1'b0;
            sel_sram   <= 1'b0;
            sel_wram   <= 1'b0;
            sel_io     <= 1'b0;
            open_bus   <= 1'b1;
            rom_off    <= '0;
            sram_off   <= '0;
            wram_off   <= '0;
            fast_cycle <= 1'b0;
        end else begin
            sel_rom    <= (pick.region == RGN_ROM);
            sel_sram   <= (pick.region == RGN_SRAM);
            sel_wram   <= (pick.region == RGN_WRAM);
            sel_io     <= (pick.region == RGN_IO);
            open_bus   <= (pick.region == RGN_NONE);
            rom_off    <= (pick.region == RGN_ROM)  ? pick.rom : '0;
            sram_off   <= (pick.region == RGN_SRAM) ? (pick.sram & SRAM_MASK) : '0;
            wram_off   <= (pick.region == RGN_WRAM) ? pick.wram : '0;
            fast_cycle <= bank[7] & speed_q;
        end
    end

    // R1: one and only one target reported.
    assert_one_target_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({sel_rom, sel_sram, sel_wram, sel_io, open_bus}) == 1);

    // R1: offsets stay zero for unselected targets.
    assert_idle_offsets_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_rom -> rom_off == '0) && (!sel_sram -> sram_off == '0) &&
        (!sel_wram -> wram_off == '0));

    // R5: the two WRAM banks always answer as WRAM.
    assert_wram_banks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(bus_addr[23:17] == 7'h3F) |-> sel_wram);

    // R3: the 32 KB layout never puts ROM in a lower bank half.
    assert_lo_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(!map_hi && !bus_addr[15]) |-> !sel_rom);

    // R7: page $21 of a system bank is always the register window.
    assert_io_page_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(!bus_addr[22] && bus_addr[15:8] == 8'h21) |-> sel_io);

    // R10: the fast flag only follows an address in the upper bank half.
    assert_fast_upper_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fast_cycle |-> $past(bus_addr[23]));
endmodule

// File: tb/cart_map_decoder_bench.sv
module cart_map_decoder_bench;
    localparam int SRAM_AW = 13;
    localparam int SRAM_SZ = 1 << SRAM_AW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] bus_addr = '0;
    logic        map_hi = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_speed_bit = 1'b0;
    logic        sel_rom, sel_sram, sel_wram, sel_io, open_bus, fast_cycle;
    logic [21:0] rom_off;
    logic [18:0] sram_off;
    logic [16:0] wram_off;

    int checks = 0;
    int errors = 0;
    bit spd_model = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cart_map_decoder #(.SRAM_AW(SRAM_AW)) u_cart_map_decoder (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .map_hi(map_hi),
        .wr_en(wr_en), .wr_speed_bit(wr_speed_bit),
        .sel_rom(sel_rom), .sel_sram(sel_sram), .sel_wram(sel_wram),
        .sel_io(sel_io), .open_bus(open_bus), .rom_off(rom_off),
        .sram_off(sram_off), .wram_off(wram_off), .fast_cycle(fast_cycle)
    );

    // Behavioural model: 0 none, 1 ROM, 2 SRAM, 3 WRAM, 4 IO.
    task automatic model(input int bank, input int off, input bit hi, input bit spd,
                         output int rg, output int ro, output int so, output int wo,
                         output bit fst, output string tag);
        int lo = bank & 'h7F;
        rg = 0; ro = 0; so = 0; wo = 0; tag = "R11";
        if (bank == 'h7E || bank == 'h7F) begin
            rg = 3; wo = ((bank & 1) << 16) | off; tag = "R5";
        end else if (lo < 'h40 && off < 'h2000) begin
            rg = 3; wo = off; tag = "R6";
        end else if (lo < 'h40 && ((off >= 'h2100 && off <= 'h21FF) ||
                                   (off >= 'h4200 && off <= 'h44FF))) begin
            rg = 4; tag = "R7";
        end else if (!hi) begin
            if (off >= 'h8000) begin
                rg = 1; ro = (lo << 15) | (off & 'h7FFF); tag = "R3";
            end else if ((lo >= 'h70 && lo <= 'h7D) || bank >= 'hFE) begin
                rg = 2; so = (((bank & 'hF) << 15) | off) % SRAM_SZ; tag = "R8";
            end
        end else begin
            if (lo >= 'h40 || off >= 'h8000) begin
                rg = 1; ro = ((bank & 'h3F) << 16) | off; tag = "R4";
            end else if (lo >= 'h20 && off >= 'h6000) begin
                rg = 2; so = (((bank & 'h1F) << 13) | (off & 'h1FFF)) % SRAM_SZ; tag = "R9";
            end
        end
        fst = (bank >= 'h80) && spd;
    endtask

    // Compare outputs against expected values.
    task automatic compare(input int rg, input int ro, input int so, input int wo,
                           input bit fst, input string tag);
        int act_rg;
        checks++;
        act_rg = sel_rom ? 1 : sel_sram ? 2 : sel_wram ? 3 : sel_io ? 4 : 0;
        if ($countones({sel_rom, sel_sram, sel_wram, sel_io, open_bus}) != 1) begin
            errors++;
            $display("FAIL R1: selects %b expected exactly one high",
                     {sel_rom, sel_sram, sel_wram, sel_io, open_bus});
        end else if (act_rg != rg || int'(rom_off) != ro || int'(sram_off) != so ||
                     int'(wram_off) != wo) begin
            errors++;
            $display("FAIL %s (R2): addr region/rom/sram/wram act %0d/%h/%h/%h exp %0d/%h/%h/%h",
                     tag, act_rg, rom_off, sram_off, wram_off, rg, ro, so, wo);
        end else if (fast_cycle != fst) begin
            errors++;
            $display("FAIL R10: fast_cycle act %0b exp %0b", fast_cycle, fst);
        end
    endtask

    // Drive one address, check it one clock later, then update the speed model.
    task automatic step(input int bank, input int off, input bit hi,
                        input bit we = 0, input bit wb = 0);
        int rg, ro, so, wo;
        bit fst;
        string tag;
        @(negedge clk);
        bus_addr = 24'((bank << 16) | off);
        map_hi = hi; wr_en = we; wr_speed_bit = wb;
        model(bank, off, hi, spd_model, rg, ro, so, wo, fst, tag);
        @(posedge clk);
        #2;
        compare(rg, ro, so, wo, fst, tag);
        if (we && (bank & 'h40) == 0 && off == 'h420D) spd_model = wb;
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1: reset state.
        compare(0, 0, 0, 0, 0, "R1");
        @(negedge clk);
        rst_n = 1'b1;

        // R3: 32 KB layout ROM.
        step('h00, 'h8000, 0); step('h3F, 'hFFFF, 0); step('h12, 'hABCD, 0);
        // R5: mirrors, WRAM banks, top chunks via FE/FF.
        step('h80, 'h8000, 0); step('hFE, 'h8000, 0); step('hFF, 'hFFFF, 0);
        step('h7E, 'h8000, 0); step('h7F, 'h1234, 0); step('h7E, 'h0000, 1);
        // R6: low-RAM shadow.
        step('h00, 'h0100, 0); step('h80, 'h1FFF, 0); step('h3F, 'h0ABC, 1);
        // R7: register window.
        step('h00, 'h2100, 0); step('hBF, 'h4300, 1); step('h00, 'h44FF, 0);
        // R11: holes.
        step('h00, 'h2000, 0); step('h40, 'h0000, 0); step('h00, 'h6000, 0);
        step('h00, 'h6000, 1); step('h1F, 'h7000, 1); step('h00, 'h4500, 1);
        // R8: SRAM in 32 KB layout, wraps every 8 KB.
        step('h70, 'h0000, 0); step('h70, 'h2005, 0); step('h7D, 'h7FFF, 0);
        step('hFE, 'h0010, 0); step('hF3, 'h1234, 0);
        // R4: 64 KB layout ROM.
        step('h40, 'h0000, 1); step('h7D, 'hFFFF, 1); step('hC0, 'h0019, 1);
        step('hFE, 'h0000, 1); step('hFF, 'hFFFF, 1); step('h00, 'h8000, 1);
        step('h20, 'h8000, 1); step('h40, 'h2100, 1);
        // R9: 64 KB layout SRAM.
        step('h20, 'h6000, 1); step('h3F, 'h7FFF, 1); step('hA1, 'h6001, 1);
        // R10: speed register.
        step('h80, 'h8000, 0);
        step('h00, 'h420D, 0, 1, 1);
        step('h80, 'h8000, 0); step('h00, 'h8000, 0);
        step('h00, 'h420C, 0, 1, 0);
        step('hC0, 'h0000, 1);
        step('h40, 'h420D, 0, 1, 0);
        step('hFF, 'h8000, 0);
        step('h80, 'h420D, 0, 1, 0);
        step('h80, 'h8000, 0);
        step('h00, 'h420D, 0, 0, 1);
        step('h80, 'h8000, 0);

        // R2: varied patterns one per clock, including occasional stores.
        for (int i = 0; i < 3000; i++) begin
            int b = int'($urandom_range(0, 255));
            int o = int'($urandom_range(0, 65535));
            bit w = ($urandom_range(0, 7) == 0);
            if ($urandom_range(0, 5) == 0) o = 'h420D;
            step(b, o, bit'($urandom_range(0, 1)), w, bit'($urandom_range(0, 1)));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R2: watchdog expired act running exp finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule